// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block is a purely combinational unsigned multiplier. It takes two operands of `WIDTH` bits each, the multiplicand and the multiplier, and returns their full product on `2*WIDTH` bits. `WIDTH` defaults to 4. There is no clock, no reset and no handshake. The product follows the operands after the delay of the logic.

An AND plane forms one partial-product bit for every pair of multiplicand and multiplier bits. Rows of full adders add the partial products. Each row sends its carries down to the next row instead of along itself, so a row is only one full adder deep. Each row also retires one low-order product bit. After the last row, the remaining sum and carry vectors still have to be combined. A single ripple-carry row merges them into the upper half of the product. Without that merge row the upper bits would be wrong.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of operands, `product` equals the unsigned arithmetic product `mcand * mplier`, carried on `2*WIDTH` bits.
- R2: `product[0]` equals `mcand[0] AND mplier[0]` for every operand pair.
- R3: When `mplier` has exactly one bit set, at position j, `product` equals `mcand` shifted left by j places.
- R4: When either operand is zero, every bit of `product` is zero.
- R5: For each k below `WIDTH`, product bits k down to 0 depend only on operand bits k down to 0. They equal the low k+1 bits of the product of the operands taken modulo 2^(k+1).
- R6: With both operands all ones, `product` equals (2^WIDTH - 1)^2. For `WIDTH` = 4 that is 225, binary 11100001. This case makes carries cross the whole merge row, and the merge row never produces a carry out of its top position.
- R7: For `WIDTH` = 4, multiplicand 1011 times multiplier 1101 gives 10001111 (11 times 13 is 143).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WIDTH | Unsigned multiplicand |
| mplier | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product |

## Verification
The case that is hardest to reach is a carry that enters the merge row at its lowest position and has to travel through every later position. Only operands whose partial products leave saved carries at the bottom, with matching sums above them, do this. The all-ones pair is the clearest example. The bench does not search for such operands: it sweeps every pair of 4-bit operands, so every carry pattern through the array rows and the merge row occurs. At each pair it also compares the low product bits against truncated products, which shows that each array row retires the right bit.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

    // Result of one full-adder cell: sum and carry settle after the same delay.
    typedef struct packed {
        logic carry;
        logic sum;
    } fa_pair_t;

    function automatic fa_pair_t full_add(input logic x, input logic y, input logic z);
        fa_pair_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/mult_fa_cell.sv
module mult_fa_cell
    import csa_mult_pkg::*;
(
    input  logic x_in,
    input  logic y_in,
    input  logic z_in,
    output logic sum_out,
    output logic carry_out
);

    fa_pair_t res;

    always_comb begin
        res       = full_add(x_in, y_in, z_in);
        sum_out   = res.sum;
        carry_out = res.carry;
    end

endmodule

// File: rtl/mult_pp_plane.sv
module mult_pp_plane #(
    parameter int W = 4
) (
    input  logic [W-1:0]        mcand,
    input  logic [W-1:0]        mplier,
    output logic [W-1:0][W-1:0] pp_rows   // pp_rows[j][i] = mcand[i] & mplier[j]
);

    for (genvar j = 0; j < W; j++) begin : g_row
        for (genvar i = 0; i < W; i++) begin : g_col
            assign pp_rows[j][i] = mcand[i] & mplier[j];
        end
    end

endmodule

// File: rtl/mult_csa_row.sv
module mult_csa_row #(
    parameter int W = 4
) (
    input  logic [W-1:0] pp_row,     // partial products of this row, weight-aligned
    input  logic [W-1:0] sum_in,     // earlier sums, already shifted into alignment
    input  logic [W-1:0] carry_in,   // carries saved by the row above
    output logic [W-1:0] sum_out,
    output logic [W-1:0] carry_out   // saved for the next row, never rippled here
);

    for (genvar i = 0; i < W; i++) begin : g_cell
        mult_fa_cell u_fa (
            .x_in      (pp_row[i]),
            .y_in      (sum_in[i]),
            .z_in      (carry_in[i]),
            .sum_out   (sum_out[i]),
            .carry_out (carry_out[i])
        );
    end

endmodule

// File: rtl/mult_ripple_merge.sv
module mult_ripple_merge #(
    parameter int W = 4
) (
    input  logic [W-1:0] sum_vec,
    input  logic [W-1:0] carry_vec,
    output logic [W-1:0] result,
    output logic         carry_top
);

    logic [W:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_pos
        mult_fa_cell u_fa (
            .x_in      (sum_vec[i]),
            .y_in      (carry_vec[i]),
            .z_in      (chain[i]),
            .sum_out   (result[i]),
            .carry_out (chain[i+1])
        );
    end

    assign carry_top = chain[W];

endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
    parameter int WIDTH = 4       // operand width, at least 2
) (
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0][WIDTH-1:0] pp_rows;
    logic [WIDTH-1:0]            row_sum [WIDTH];
    logic [WIDTH-1:0]            row_cry [WIDTH];
    logic [WIDTH-1:0]            merge_hi;
    logic                        merge_cout;

    mult_pp_plane #(.W(WIDTH)) u_pp (
        .mcand   (mcand),
        .mplier  (mplier),
        .pp_rows (pp_rows)
    );

    // Row 0 is the first partial product on its own, with no saved carries.
    assign row_sum[0] = pp_rows[0];
    assign row_cry[0] = '0;

    // Each array row drops the lowest earlier sum bit, which becomes a product bit.
    for (genvar j = 1; j < WIDTH; j++) begin : g_array
        mult_csa_row #(.W(WIDTH)) u_row (
            .pp_row    (pp_rows[j]),
            .sum_in    ({1'b0, row_sum[j-1][WIDTH-1:1]}),
            .carry_in  (row_cry[j-1]),
            .sum_out   (row_sum[j]),
            .carry_out (row_cry[j])
        );
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_low
        assign product[k] = row_sum[k][0];
    end

    mult_ripple_merge #(.W(WIDTH)) u_merge (
        .sum_vec   ({1'b0, row_sum[WIDTH-1][WIDTH-1:1]}),
        .carry_vec (row_cry[WIDTH-1]),
        .result    (merge_hi),
        .carry_top (merge_cout)
    );

    assign product[PW-1:WIDTH] = merge_hi;

endmodule

// File: rtl/csa_array_mult_chk.sv
module csa_array_mult_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0]   mcand,
    input logic [WIDTH-1:0]   mplier,
    input logic [2*WIDTH-1:0] product,
    input logic               merge_cout
);

    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] wide_a;
    logic [PW-1:0] wide_b;

    assign wide_a = {{WIDTH{1'b0}}, mcand};
    assign wide_b = {{WIDTH{1'b0}}, mplier};

    always_comb begin
        p_full_product_r1: assert (product == PW'(wide_a * wide_b))
            else $error("R1 product mismatch");
        p_lsb_r2: assert (product[0] == (mcand[0] & mplier[0]))
            else $error("R2 lowest bit mismatch");
        if (mcand == '0 || mplier == '0) begin
            p_zero_operand_r4: assert (product == '0)
                else $error("R4 zero operand gave nonzero product");
        end
        for (int j = 0; j < WIDTH; j++) begin
            if (mplier == WIDTH'(1 << j)) begin
                p_single_row_r3: assert (product == (wide_a << j))
                    else $error("R3 single-bit multiplier mismatch");
            end
        end
        p_no_lost_carry_r6: assert (merge_cout == 1'b0)
            else $error("R6 merge row carried out of its top position");
    end

endmodule

bind csa_array_mult csa_array_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .mcand      (mcand),
    .mplier     (mplier),
    .product    (product),
    .merge_cout (merge_cout)
);

// File: tb/csa_array_mult_tb.sv
module csa_array_mult_tb;

    localparam int N  = 4;
    localparam int PW = 2 * N;

    logic          clk = 1'b0;
    logic [N-1:0]  mcand;
    logic [N-1:0]  mplier;
    logic [PW-1:0] product;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    csa_array_mult #(.WIDTH(N)) u_dut (
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: mcand=%0d mplier=%0d actual=%0d expected=%0d",
                     req, mcand, mplier, act, exp);
        end
    endtask

    // Drive after a rising edge, sample at the following falling edge.
    task automatic apply(input int a, input int b);
        @(posedge clk);
        mcand  <= N'(a);
        mplier <= N'(b);
        @(negedge clk);
    endtask

    initial begin
        mcand  = '0;
        mplier = '0;

        // R4: initial state with both operands at zero
        @(negedge clk);
        check("R4 initial zero", int'(product), 0);

        // R7: worked example 1011 x 1101
        apply(4'b1011, 4'b1101);
        check("R7 11x13", int'(product), 8'b1000_1111);

        // R6: all ones forces the longest carry travel
        apply(15, 15);
        check("R6 all ones", int'(product), 225);

        // Exhaustive sweep: R1, R2, R5, with R4 and R3 on their sub-cases
        for (int a = 0; a < (1 << N); a++) begin
            for (int b = 0; b < (1 << N); b++) begin
                apply(a, b);
                check("R1 full product", int'(product), a * b);
                check("R2 lowest bit", int'(product[0]), (a & 1) & (b & 1));
                for (int k = 0; k < N; k++) begin
                    int msk = (1 << (k + 1)) - 1;
                    check("R5 low bits", int'(product) & msk,
                          ((a & msk) * (b & msk)) & msk);
                end
                if (a == 0 || b == 0)
                    check("R4 zero operand", int'(product), 0);
            end
        end

        // R3: single-bit multiplier selects one partial-product row
        for (int a = 0; a < (1 << N); a++) begin
            for (int j = 0; j < N; j++) begin
                apply(a, 1 << j);
                check("R3 single row", int'(product), a << j);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule